// File: doc/BRIEF.md
# Clock-Divider Transition Sequencer

This block moves a core clock between the divide ratios 1, 2, 4, 6 and 8. A request carries a ratio index and is accepted with a valid/ready handshake. The block keeps the memory controller's refresh settings correct during the change. It owns two registers. The first is a mode register, whose three low bits select the divider. The second is a memory-control register, which holds a 7-bit refresh count and a self-refresh enable bit.

Each change runs as a fixed series of single register updates, with counted waits between some of them. A divider write is always followed by a wait for the clock generator to lock. In some cases a refresh-count update is followed by a wait for the old and new refresh counts to drain. Moves between ratio 1 and ratio 4, 6 or 8 always pass through ratio 2. The refresh count for each ratio is computed at elaboration from the clock frequency parameter. A one-cycle `done` pulse reports the end of a change. A one-cycle `err` pulse reports an index that is out of range.

Top module: `clkdiv_seq`

## Requirements
- R1: After reset the divider selects /1, self-refresh is off, the refresh count holds the /1 value, `req_ready` is high, and `done` and `err` are low.
- R2: The ratio index maps to the divider code as follows: 0→/1 code 000, 1→/2 code 001, 2→/4 code 011, 3→/6 code 010, 4→/8 code 100. The code sits in mode bits 2:0. Mode bits above bit 2 never change.
- R3: After a change completes, memory-control bits 14:8 hold floor(CLK_HZ·7800 / (64·ratio·10^9)) for the new ratio. Bit 16, the self-refresh enable, is 1 for every ratio except /1. All other memory-control bits never change.
- R4: After every divider write, at least LOCK_CYCLES (default 16) clock cycles pass before the next register update or `done`.
- R5: A move from /2 to /1 clears self-refresh first, then writes the divider, then writes the refresh count.
- R6: A move from /1 to /2 first writes the refresh count, then writes the divider, then sets self-refresh. If self-refresh is off when the count is written, at least 64·(old count + new count)·(old ratio) cycles pass before the divider write.
- R7: A move from /1 to /4, /6 or /8, or from one of those to /1, runs as two complete moves through /2. The divider never switches directly between code 000 and any code other than 001.
- R8: Between two ratios that are both 2 or above, a larger ratio gets the refresh count written before the divider. A smaller ratio gets the divider written first and the count after it; in that case the drain wait of R6, based on the old ratio, applies when self-refresh is off.
- R9: A request whose target equals the current ratio pulses `done` without changing any register.
- R10: A request with an index above 4 produces a one-cycle `err` pulse, no `done`, and no register change.
- R11: `req_ready` is high only when the block is idle. It is low from the cycle after acceptance through the `done` cycle. `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_index | input | 3 | Target ratio index, 0 to 4 |
| req_ready | output | 1 | High when a request can be accepted |
| done | output | 1 | One-cycle pulse at the end of a request |
| err | output | 1 | One-cycle pulse for an out-of-range index |
| mode_reg | output | MODE_W | Mode register; bits 2:0 hold the divider code |
| mem_ctl | output | MEM_W | Memory-control register; bits 14:8 hold the refresh count, bit 16 the self-refresh enable |

## Verification
The bench logs every observed change of the divider code, the refresh count and the self-refresh bit, with the cycle in which it became visible. It compares that log against the expected order of updates and the minimum spacing between them.

The targeted corners are the following:
- Two-stage moves out of and back into /1. A sequencer that skips the /2 stop would show a single divider change from 000 straight to 011, 010 or 100.
- The drain wait on the /1→/2 step. A sequencer that misses it would show the divider write only a few cycles after the count write.
- The lock wait after each divider write. Skipping it leaves a gap of one or two cycles.
- Reversed grow and shrink orders. These show up as swapped entries in the log.
- Same-ratio requests and out-of-range requests. Mishandling either changes a register or sends the wrong pulse.

// File: rtl/clkdiv_seq_pkg.sv
`timescale 1ns/1ps
package clkdiv_seq_pkg;

    localparam int          NUM_RATIOS     = 5;
    localparam int          IDX_W          = 3;
    localparam int          SEL_W          = 3;
    localparam int          REFR_LSB       = 8;
    localparam int          REFR_W         = 7;
    localparam int          SREF_BIT       = 16;
    localparam int unsigned CLKS_PER_UNIT  = 64;
    localparam longint unsigned REFR_PERIOD_NS = 64'd7800;

    typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WAIT, ST_DONE} seq_state_e;
    typedef enum logic [1:0] {LEG_DOWN_TO_1, LEG_UP_FROM_1, LEG_GROW, LEG_SHRINK} leg_kind_e;
    typedef enum logic [2:0] {OP_SREF_OFF, OP_SEL_WR, OP_REFR_WR, OP_SREF_ON, OP_LEG_END} seq_op_e;

    // Divide ratio for a ratio index.
    function automatic int unsigned ratio_of(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 8;
            default: return 1;
        endcase
    endfunction

    // Divider select code for a ratio index.
    function automatic logic [SEL_W-1:0] sel_code(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd1:    return 3'b001;
            3'd2:    return 3'b011;
            3'd3:    return 3'b010;
            3'd4:    return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    // Ratio index for a divider select code.
    function automatic logic [IDX_W-1:0] sel_to_idx(input logic [SEL_W-1:0] code);
        case (code)
            3'b001:  return 3'd1;
            3'b011:  return 3'd2;
            3'b010:  return 3'd3;
            3'b100:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    // Refresh count for a clock frequency and divide ratio, saturated to the field width.
    function automatic logic [REFR_W-1:0] refr_calc(input longint unsigned clk_hz,
                                                     input int unsigned     ratio);
        longint unsigned num;
        longint unsigned den;
        longint unsigned q;
        num = clk_hz * REFR_PERIOD_NS;
        den = 64'(CLKS_PER_UNIT) * 64'(ratio) * 64'd1_000_000_000;
        q   = num / den;
        if (q > 64'd127) q = 64'd127;
        return q[REFR_W-1:0];
    endfunction

    // Kind of one leg between two ratio indices.
    function automatic leg_kind_e leg_kind(input logic [IDX_W-1:0] from_idx,
                                           input logic [IDX_W-1:0] to_idx);
        if (from_idx == 3'd1 && to_idx == 3'd0) return LEG_DOWN_TO_1;
        if (from_idx == 3'd0 && to_idx == 3'd1) return LEG_UP_FROM_1;
        if (to_idx > from_idx)                  return LEG_GROW;
        return LEG_SHRINK;
    endfunction

    // Operation at a given step of a leg.
    function automatic seq_op_e leg_op(input leg_kind_e kind, input logic [1:0] step);
        case (kind)
            LEG_DOWN_TO_1: begin
                if (step == 2'd0) return OP_SREF_OFF;
                if (step == 2'd1) return OP_SEL_WR;
                if (step == 2'd2) return OP_REFR_WR;
                return OP_LEG_END;
            end
            LEG_UP_FROM_1: begin
                if (step == 2'd0) return OP_REFR_WR;
                if (step == 2'd1) return OP_SEL_WR;
                if (step == 2'd2) return OP_SREF_ON;
                return OP_LEG_END;
            end
            LEG_GROW: begin
                if (step == 2'd0) return OP_REFR_WR;
                if (step == 2'd1) return OP_SEL_WR;
                return OP_LEG_END;
            end
            default: begin
                if (step == 2'd0) return OP_SEL_WR;
                if (step == 2'd1) return OP_REFR_WR;
                return OP_LEG_END;
            end
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_refr_table.sv
`timescale 1ns/1ps
module clkdiv_refr_table
    import clkdiv_seq_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd500_000_000
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [REFR_W-1:0] cnt
);

    logic [REFR_W-1:0] tbl [NUM_RATIOS];

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_ent
        localparam logic [REFR_W-1:0] ENT_CNT = refr_calc(CLK_HZ, ratio_of(IDX_W'(i)));
        assign tbl[i] = ENT_CNT;
    end

    always_comb begin
        cnt = tbl[0];
        for (int k = 0; k < NUM_RATIOS; k++) begin
            if (idx == IDX_W'(k)) cnt = tbl[k];
        end
    end

endmodule

// File: rtl/clkdiv_wait_timer.sv
`timescale 1ns/1ps
module clkdiv_wait_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                cnt_d = load_val;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    AST_TMR_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy); // R4

endmodule

// File: rtl/clkdiv_seq.sv
`timescale 1ns/1ps
module clkdiv_seq
    import clkdiv_seq_pkg::*;
#(
    parameter longint unsigned           CLK_HZ       = 64'd500_000_000,
    parameter int                        MODE_W       = 16,
    parameter int                        MEM_W        = 32,
    parameter logic [MODE_W-SEL_W-1:0]   MODE_HI_RST  = '0,
    parameter int                        LOCK_CYCLES  = 16,
    parameter int                        DRAIN_MARGIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_index,
    output logic              req_ready,
    output logic              done,
    output logic              err,
    output logic [MODE_W-1:0] mode_reg,
    output logic [MEM_W-1:0]  mem_ctl
);

    localparam int WAIT_MAX = int'(CLKS_PER_UNIT) * 2 * (2 ** REFR_W) * 8 + DRAIN_MARGIN + LOCK_CYCLES;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam logic [IDX_W-1:0]  MAX_IDX = IDX_W'(NUM_RATIOS - 1);
    localparam logic [IDX_W-1:0]  IDX_1   = IDX_W'(0);
    localparam logic [IDX_W-1:0]  IDX_2   = IDX_W'(1);
    localparam logic [REFR_W-1:0] RST_CNT = refr_calc(CLK_HZ, 1);
    localparam logic [MEM_W-1:0]  KEEP_MASK = ~(MEM_W'((2 ** REFR_W) - 1) << REFR_LSB)
                                              & ~(MEM_W'(1) << SREF_BIT);

    typedef struct packed {
        seq_state_e        st;
        leg_kind_e         kind;
        logic [1:0]        step;
        logic [IDX_W-1:0]  leg_old;
        logic [IDX_W-1:0]  leg_new;
        logic [IDX_W-1:0]  final_idx;
        logic              hop;
        logic              err;
        logic [MODE_W-1:0] mode;
        logic [MEM_W-1:0]  mctl;
    } seq_regs_t;

    seq_regs_t          r_d, r_q;
    logic               tmr_load;
    logic [WAIT_W-1:0]  tmr_val;
    logic               tmr_busy;
    logic [IDX_W-1:0]   cur_idx;
    logic [IDX_W-1:0]   plan_leg;
    logic [REFR_W-1:0]  new_cnt;
    logic [REFR_W-1:0]  old_cnt;
    logic [WAIT_W-1:0]  drain_len;
    logic               slow_leg;
    seq_op_e            op;

    clkdiv_refr_table #(.CLK_HZ(CLK_HZ)) u_refr_table (
        .idx (r_q.leg_new),
        .cnt (new_cnt)
    );

    clkdiv_wait_timer #(.CNT_W(WAIT_W)) u_wait_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .busy     (tmr_busy)
    );

    assign cur_idx   = sel_to_idx(r_q.mode[SEL_W-1:0]);
    assign op        = leg_op(r_q.kind, r_q.step);
    assign old_cnt   = r_q.mctl[REFR_LSB +: REFR_W];
    assign slow_leg  = (r_q.kind == LEG_UP_FROM_1) || (r_q.kind == LEG_SHRINK);
    assign drain_len = WAIT_W'(CLKS_PER_UNIT * (32'(old_cnt) + 32'(new_cnt))
                               * ratio_of(r_q.leg_old) + 32'(DRAIN_MARGIN));

    always_comb begin
        r_d      = r_q;
        r_d.err  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        plan_leg = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_index > MAX_IDX) begin
                        r_d.err = 1'b1;
                    end else if (req_index == cur_idx) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.hop = ((cur_idx == IDX_1) && (req_index > IDX_2))
                               || ((cur_idx > IDX_2) && (req_index == IDX_1));
                        plan_leg      = r_d.hop ? IDX_2 : req_index;
                        r_d.leg_old   = cur_idx;
                        r_d.leg_new   = plan_leg;
                        r_d.final_idx = req_index;
                        r_d.kind      = leg_kind(cur_idx, plan_leg);
                        r_d.step      = 2'd0;
                        r_d.st        = ST_EXEC;
                    end
                end
            end
            ST_EXEC: begin
                case (op)
                    OP_SREF_OFF: begin
                        r_d.mctl[SREF_BIT] = 1'b0;
                        r_d.step = r_q.step + 2'd1;
                    end
                    OP_SREF_ON: begin
                        r_d.mctl[SREF_BIT] = 1'b1;
                        r_d.step = r_q.step + 2'd1;
                    end
                    OP_SEL_WR: begin
                        r_d.mode[SEL_W-1:0] = sel_code(r_q.leg_new);
                        r_d.step = r_q.step + 2'd1;
                        tmr_load = 1'b1;
                        tmr_val  = WAIT_W'(LOCK_CYCLES);
                        r_d.st   = ST_WAIT;
                    end
                    OP_REFR_WR: begin
                        r_d.mctl[REFR_LSB +: REFR_W] = new_cnt;
                        r_d.step = r_q.step + 2'd1;
                        if (slow_leg && !r_q.mctl[SREF_BIT]) begin
                            tmr_load = 1'b1;
                            tmr_val  = drain_len;
                            r_d.st   = ST_WAIT;
                        end
                    end
                    default: begin
                        if (r_q.hop) begin
                            r_d.leg_old = r_q.leg_new;
                            r_d.leg_new = r_q.final_idx;
                            r_d.kind    = leg_kind(r_q.leg_new, r_q.final_idx);
                            r_d.hop     = 1'b0;
                            r_d.step    = 2'd0;
                        end else begin
                            r_d.st = ST_DONE;
                        end
                    end
                endcase
            end
            ST_WAIT: begin
                if (!tmr_busy) r_d.st = ST_EXEC;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q                          <= '0;
            r_q.mode                     <= {MODE_HI_RST, SEL_W'(0)};
            r_q.mctl[REFR_LSB +: REFR_W] <= RST_CNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign done      = (r_q.st == ST_DONE);
    assign err       = r_q.err;
    assign mode_reg  = r_q.mode;
    assign mem_ctl   = r_q.mctl;

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_reg[2:0] inside {3'b000, 3'b001, 3'b011, 3'b010, 3'b100})); // R2
    AST_MODE_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_reg[MODE_W-1:SEL_W])); // R2
    AST_MCTL_OTHER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mem_ctl & KEEP_MASK)); // R3
    AST_SEL_WR_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_EXEC && op == OP_SEL_WR) |=> tmr_busy); // R4
    AST_SREF_OFF_AT_DIV2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ctl[SREF_BIT]) |-> (mode_reg[2:0] == 3'b001)); // R5
    AST_SREF_ON_AT_DIV2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ctl[SREF_BIT]) |-> (mode_reg[2:0] == 3'b001)); // R6
    AST_NO_SKIP_DIV2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_reg[2:0] != $past(mode_reg[2:0]))
         && (mode_reg[2:0] == 3'b000 || $past(mode_reg[2:0]) == 3'b000))
        |-> ((mode_reg[2:0] | $past(mode_reg[2:0])) == 3'b001)); // R7
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(mode_reg) && $stable(mem_ctl) && req_ready && !done)); // R10
    AST_READY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && done)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

endmodule

// File: tb/clkdiv_seq_tb.sv
`timescale 1ns/1ps
module clkdiv_seq_tb;

    localparam longint unsigned TB_CLK_HZ = 64'd100_000_000;
    localparam int              TB_LOCK   = 16;
    localparam logic [12:0]     TB_HI     = 13'h1A5B;
    localparam int              WD_LIMIT  = 190000;
    localparam int EV_OFF = 1, EV_SEL = 2, EV_REFR = 3, EV_ON = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_index = 3'd0;
    logic        req_ready, done, err;
    logic [15:0] mode_reg;
    logic [31:0] mem_ctl;

    int n_chk = 0;
    int n_fail = 0;
    longint cyc = 0;

    clkdiv_seq #(
        .CLK_HZ      (TB_CLK_HZ),
        .MODE_W      (16),
        .MEM_W       (32),
        .MODE_HI_RST (TB_HI),
        .LOCK_CYCLES (TB_LOCK),
        .DRAIN_MARGIN(4)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_index (req_index),
        .req_ready (req_ready),
        .done      (done),
        .err       (err),
        .mode_reg  (mode_reg),
        .mem_ctl   (mem_ctl)
    );

    always #4 clk = ~clk;

    function automatic int b_ratio(input int idx);
        case (idx) 1: return 2; 2: return 4; 3: return 6; 4: return 8; default: return 1; endcase
    endfunction

    function automatic int b_code(input int idx);
        case (idx) 1: return 1; 2: return 3; 3: return 2; 4: return 4; default: return 0; endcase
    endfunction

    function automatic int b_refr(input int idx);
        longint unsigned q;
        q = (TB_CLK_HZ * 64'd7800) / (64'd64 * 64'(b_ratio(idx)) * 64'd1_000_000_000);
        return int'(q);
    endfunction

    // observed event log, written only by the monitor
    int     obs_kind [512];
    int     obs_val  [512];
    longint obs_cyc  [512];
    int     obs_n = 0;
    logic [2:0] prv_sel = 3'd0;
    logic [6:0] prv_refr = 7'd0;
    logic       prv_sr = 1'b0;
    logic       mon_en = 1'b0;

    always @(negedge clk) begin
        if (mon_en && obs_n < 500) begin
            if (mode_reg[2:0] != prv_sel) begin
                obs_kind[obs_n] = EV_SEL; obs_val[obs_n] = int'(mode_reg[2:0]);
                obs_cyc[obs_n] = cyc; obs_n = obs_n + 1;
            end
            if (mem_ctl[14:8] != prv_refr) begin
                obs_kind[obs_n] = EV_REFR; obs_val[obs_n] = int'(mem_ctl[14:8]);
                obs_cyc[obs_n] = cyc; obs_n = obs_n + 1;
            end
            if (mem_ctl[16] != prv_sr) begin
                obs_kind[obs_n] = mem_ctl[16] ? EV_ON : EV_OFF; obs_val[obs_n] = 0;
                obs_cyc[obs_n] = cyc; obs_n = obs_n + 1;
            end
        end
        prv_sel  = mode_reg[2:0];
        prv_refr = mem_ctl[14:8];
        prv_sr   = mem_ctl[16];
    end

    task automatic summary_and_finish();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL R11 watchdog expired: actual=%0d expected<%0d", cyc, WD_LIMIT);
            summary_and_finish();
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // expected sequence model
    int     exp_kind [16];
    int     exp_val  [16];
    longint exp_gap  [16];
    string  exp_tag  [16];
    int     exp_n;
    int     m_idx = 0;
    bit     m_sr  = 1'b0;

    task automatic push(input int k, input int v, input longint g, input string t);
        exp_kind[exp_n] = k; exp_val[exp_n] = v; exp_gap[exp_n] = g; exp_tag[exp_n] = t;
        exp_n = exp_n + 1;
    endtask

    task automatic add_leg(input int o, input int n);
        longint dg;
        dg = m_sr ? 0 : longint'(64 * (b_refr(o) + b_refr(n)) * b_ratio(o));
        if (o == 1 && n == 0) begin
            push(EV_OFF, 0, 0, "R5");
            push(EV_SEL, b_code(0), TB_LOCK, "R5");
            push(EV_REFR, b_refr(0), 0, "R5");
            m_sr = 1'b0;
        end else if (o == 0 && n == 1) begin
            push(EV_REFR, b_refr(1), dg, "R6");
            push(EV_SEL, b_code(1), TB_LOCK, "R6");
            push(EV_ON, 0, 0, "R6");
            m_sr = 1'b1;
        end else if (n > o) begin
            push(EV_REFR, b_refr(n), 0, "R8");
            push(EV_SEL, b_code(n), TB_LOCK, "R8");
        end else begin
            push(EV_SEL, b_code(n), TB_LOCK, "R8");
            push(EV_REFR, b_refr(n), dg, "R8");
        end
    endtask

    task automatic do_req(input int tgt, input string tag);
        int     base;
        int     waitc;
        bit     ready_bad;
        bit     hop;
        longint done_c;
        longint nxt;
        exp_n = 0;
        hop   = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "ready before request", req_ready, 1);
        if (tgt <= 4 && tgt != m_idx) begin
            if (m_idx == 0 && tgt > 1) begin hop = 1'b1; add_leg(0, 1); add_leg(1, tgt); end
            else if (m_idx > 1 && tgt == 0) begin hop = 1'b1; add_leg(m_idx, 1); add_leg(1, 0); end
            else add_leg(m_idx, tgt);
            m_idx = tgt;
        end
        base      = obs_n;
        req_valid = 1'b1;
        req_index = 3'(tgt);
        @(negedge clk);
        req_valid = 1'b0;
        waitc     = 0;
        ready_bad = 1'b0;
        while (!done && !err && waitc < 20000) begin
            if (req_ready) ready_bad = 1'b1;
            @(negedge clk);
            waitc = waitc + 1;
        end
        done_c = cyc;
        check(!ready_bad, "R11", "ready low while busy", ready_bad, 0);
        if (tgt > 4) begin
            check(err == 1'b1 && done == 1'b0, "R10", "err pulse for bad index", {err, done}, 2);
            @(negedge clk);
            check(err == 1'b0, "R10", "err lasts one cycle", err, 0);
            check(obs_n == base, "R10", "no register change on bad index", obs_n - base, 0);
        end else begin
            check(done == 1'b1, "R11", "done seen", done, 1);
            @(negedge clk);
            check(done == 1'b0 && req_ready == 1'b1, "R11", "done one cycle then ready",
                  {done, req_ready}, 1);
            check(obs_n - base == exp_n, exp_n == 0 ? "R9" : (hop ? "R7" : tag),
                  "update count", obs_n - base, exp_n);
            if (obs_n - base == exp_n) begin
                for (int i = 0; i < exp_n; i++) begin
                    check(obs_kind[base+i] == exp_kind[i] && obs_val[base+i] == exp_val[i],
                          exp_tag[i], "update kind*256+value",
                          obs_kind[base+i] * 256 + obs_val[base+i], exp_kind[i] * 256 + exp_val[i]);
                    nxt = (i + 1 < exp_n) ? obs_cyc[base+i+1] : done_c;
                    if (exp_gap[i] > 0)
                        check(nxt - obs_cyc[base+i] >= exp_gap[i],
                              exp_kind[i] == EV_SEL ? "R4" : exp_tag[i], "spacing after update",
                              nxt - obs_cyc[base+i], exp_gap[i]);
                end
            end
            check(int'(mode_reg[2:0]) == b_code(tgt), "R2", "divider code", mode_reg[2:0], b_code(tgt));
            check(int'(mem_ctl[14:8]) == b_refr(tgt), "R3", "refresh count", mem_ctl[14:8], b_refr(tgt));
            check(mem_ctl[16] == (tgt != 0), "R3", "self-refresh bit", mem_ctl[16], tgt != 0);
        end
        check(mode_reg[15:3] == TB_HI, "R2", "mode upper bits", mode_reg[15:3], TB_HI);
        check((mem_ctl & ~32'h0001_7F00) == 32'd0, "R3", "memctl other bits",
              mem_ctl & ~32'h0001_7F00, 0);
    endtask

    initial begin
        int r;
        int seed_dummy;
        seed_dummy = $urandom(32'd20240);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mode_reg == {TB_HI, 3'b000}, "R1", "mode after reset", mode_reg, {TB_HI, 3'b000});
        check(int'(mem_ctl[14:8]) == b_refr(0), "R1", "refresh count after reset", mem_ctl[14:8], b_refr(0));
        check(mem_ctl[16] == 1'b0, "R1", "self-refresh after reset", mem_ctl[16], 0);
        check(req_ready && !done && !err, "R1", "handshake after reset", {req_ready, done, err}, 4);
        mon_en = 1'b1;

        do_req(0, "R9");   // same ratio at /1
        do_req(1, "R6");   // /1 -> /2
        do_req(0, "R5");   // /2 -> /1
        do_req(2, "R7");   // /1 -> /4 through /2
        do_req(3, "R8");   // grow /4 -> /6
        do_req(4, "R8");   // grow /6 -> /8
        do_req(3, "R8");   // shrink /8 -> /6
        do_req(1, "R8");   // shrink /6 -> /2
        do_req(1, "R9");   // same ratio at /2
        do_req(5, "R10");
        do_req(7, "R10");
        do_req(4, "R8");   // grow /2 -> /8
        do_req(0, "R7");   // /8 -> /1 through /2
        do_req(3, "R7");   // /1 -> /6 through /2
        do_req(6, "R10");

        for (int n = 0; n < 40; n++) begin
            r = int'($urandom % 10);
            do_req(r < 8 ? (r % 5) : 5 + (r % 3), "R8");
        end

        summary_and_finish();
    end

endmodule